// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits between a two-wire serial slave engine and a byte-wide nonvolatile array. When the slave engine has decoded a write command and a word address, it pulses a start-of-write with that address. Each received data byte then arrives on a one-cycle strobe. The block parks each byte in a 32-entry page buffer at a column taken from the low five address bits. The column advances with every byte and wraps inside the page, so the upper address bits never move. A per-column valid mask records which columns have been filled. A later byte that lands on an already filled column replaces the earlier one.

Nothing reaches the array while bytes are arriving. When the stop strobe comes, the block walks the whole page once, one column per clock, in ascending column order starting at the base column. It drives the array write port only for columns whose valid bit is set. It then holds busy for a programmable number of clocks that stands for the nonvolatile write time. A write-protect input sampled over the whole transaction, and a low-supply inhibit sampled at the stop, can each cancel the commit. At the stop the block also updates the address pointer that later current-address reads start from.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy is 0, the array write enable is 0 and the address pointer is 0.
- R2: Data byte k (counting from 0) of a transaction is stored at column (base column + k) mod 32. The column is address bits 4..0. Address bits 12..5 of every array write equal those of the start address.
- R3: When two bytes of one transaction land on the same column, only the later byte is programmed, and each column is written at most once per commit.
- R4: The array write enable stays 0 until the stop strobe, and only columns that received data are programmed.
- R5: The commit issues one write per clock, in ascending column order starting at the base column and wrapping. Busy rises in the cycle after the stop and stays high for exactly 32 + WRITE_CYCLES cycles.
- R6: If the write-protect input is high on any clock from the start-of-write through the stop, no array write occurs and busy stays 0.
- R7: If the low-supply inhibit is high when the stop strobe is taken, no array write occurs and busy stays 0.
- R8: After a transaction of 1 to 31 bytes, the pointer is {start address bits 12..5, (start column + byte count) mod 32}.
- R9: After a transaction of 32 or more bytes, the pointer equals the start address.
- R10: A single byte written at column 31 leaves the pointer at column 0 of the same page.
- R11: A stop with no data bytes writes nothing, keeps busy at 0 and loads the pointer with the start address.
- R12: While busy is high, start-of-write, data and stop strobes are ignored. They cause no extra array write, do not change the pointer and do not lengthen busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | One-cycle pulse: a write transaction begins at wr_addr |
| wr_addr | input | ADDR_W | Start word address of the transaction |
| byte_stb | input | 1 | One-cycle pulse: byte_data holds a received data byte |
| byte_data | input | DATA_W | Received data byte |
| stop_stb | input | 1 | One-cycle pulse: stop condition seen on the bus |
| wp_pin | input | 1 | Write-protect level |
| low_vdd | input | 1 | Low-supply inhibit flag |
| arr_we | output | 1 | Array write enable, one byte per cycle |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit or write-cycle timer in progress |
| ptr | output | ADDR_W | Address pointer after the last transaction |

## Verification
The bench builds the block with a 13-bit address, a 32-byte page and WRITE_CYCLES set to 20. This makes every busy window 52 cycles long, so many commits fit in a short run and the exact busy length can be counted. The short window also leaves room to inject a complete intruding transaction inside busy. The full 32-column page is kept, so the bench can exercise wrap from column 28 and from column 31, overruns of 40 bytes, and the 32-byte pointer boundary.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        PGW_IDLE,
        PGW_RECV,
        PGW_COMMIT,
        PGW_WAIT
    } pgw_state_e;

    // decoded per-cycle control of the sequencer
    typedef struct packed {
        logic clear;     // restart capture at a new base address
        logic take;      // accept a data byte into the page buffer
        logic finish;    // stop taken while receiving
        logic commit;    // stop leads into a programming run
    } pgw_ctl_t;

endpackage

// File: rtl/pgw_capture.sv
module pgw_capture #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int COL_W      = 5,
    parameter int CNT_W      = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic [COL_W-1:0]             base_col,
    input  logic                         take,
    input  logic [DATA_W-1:0]            byte_in,
    output logic [COL_W-1:0]             col_o,
    output logic [CNT_W-1:0]             count_o,
    output logic [PAGE_BYTES*DATA_W-1:0] page_data,
    output logic [PAGE_BYTES-1:0]        valid_mask
);

    logic [COL_W-1:0] col_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            col_q <= base_col;
            cnt_q <= '0;
        end else if (take) begin
            col_q <= col_q + 1'b1;
            if (cnt_q != CNT_W'(PAGE_BYTES))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
        logic hit;
        assign hit = take && (col_q == COL_W'(g));

        always_ff @(posedge clk) begin
            if (rst)
                valid_mask[g] <= 1'b0;
            else if (clear)
                valid_mask[g] <= 1'b0;
            else if (hit)
                valid_mask[g] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit)
                page_data[g*DATA_W +: DATA_W] <= byte_in;
        end
    end

    assign col_o   = col_q;
    assign count_o = cnt_q;

endmodule

// File: rtl/pgw_scan.sv
module pgw_scan #(
    parameter int PAGE_BYTES = 32,
    parameter int COL_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] base_col,
    output logic             active,
    output logic [COL_W-1:0] col,
    output logic             last
);

    logic [COL_W-1:0] idx_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            idx_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            idx_q <= '0;
        end else if (run_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == COL_W'(PAGE_BYTES - 1))
                run_q <= 1'b0;
        end
    end

    assign active = run_q;
    assign col    = base_col + idx_q;
    assign last   = run_q && (idx_q == COL_W'(PAGE_BYTES - 1));

endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
    parameter int CYCLES = 500000,
    parameter int TIM_W  = 19
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic running,
    output logic expire
);

    logic [TIM_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= TIM_W'(CYCLES - 1);
        end else if (run_q) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign running = run_q;
    assign expire  = run_q && (cnt_q == '0);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import pgw_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_stb,
    input  logic              wp_pin,
    input  logic              low_vdd,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr
);

    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = COL_W + 1;
    localparam int TIM_W = $clog2(WRITE_CYCLES + 1);
    localparam int PG_W  = ADDR_W - COL_W;

    pgw_state_e         state_q;
    pgw_ctl_t           ctl;
    logic [ADDR_W-1:0]  base_q;
    logic               prot_q;
    logic [ADDR_W-1:0]  ptr_q;

    logic [COL_W-1:0]             cap_col;
    logic [CNT_W-1:0]             cap_cnt;
    logic [PAGE_BYTES*DATA_W-1:0] cap_data;
    logic [PAGE_BYTES-1:0]        cap_mask;

    logic             scan_active;
    logic [COL_W-1:0] scan_col;
    logic             scan_last;
    logic             tim_running;
    logic             tim_expire;
    logic             recv_st;
    logic [PG_W-1:0]  base_page;
    logic             blocked;

    assign recv_st   = (state_q == PGW_RECV);
    assign base_page = base_q[ADDR_W-1:COL_W];
    assign blocked   = prot_q | wp_pin | low_vdd;

    // control decode
    always_comb begin
        ctl        = '0;
        ctl.clear  = wr_start && (state_q == PGW_IDLE || state_q == PGW_RECV);
        ctl.finish = recv_st && stop_stb && !wr_start;
        ctl.take   = recv_st && byte_stb && !stop_stb && !wr_start;
        ctl.commit = ctl.finish && (cap_cnt != '0) && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PGW_IDLE;
            base_q  <= '0;
            prot_q  <= 1'b0;
        end else begin
            unique case (state_q)
                PGW_IDLE: begin
                    if (ctl.clear) begin
                        base_q  <= wr_addr;
                        prot_q  <= wp_pin;
                        state_q <= PGW_RECV;
                    end
                end
                PGW_RECV: begin
                    if (ctl.clear) begin
                        base_q <= wr_addr;
                        prot_q <= wp_pin;
                    end else if (ctl.finish) begin
                        state_q <= ctl.commit ? PGW_COMMIT : PGW_IDLE;
                    end else begin
                        prot_q <= prot_q | wp_pin;
                    end
                end
                PGW_COMMIT: begin
                    if (scan_last)
                        state_q <= PGW_WAIT;
                end
                PGW_WAIT: begin
                    if (tim_expire)
                        state_q <= PGW_IDLE;
                end
                default: state_q <= PGW_IDLE;
            endcase
        end
    end

    // address pointer update at the stop
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ctl.finish) begin
            if (cap_cnt == '0 || cap_cnt == CNT_W'(PAGE_BYTES))
                ptr_q <= base_q;
            else
                ptr_q <= {base_page, cap_col};
        end
    end

    pgw_capture #(
        .DATA_W    (DATA_W),
        .PAGE_BYTES(PAGE_BYTES),
        .COL_W     (COL_W),
        .CNT_W     (CNT_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .clear     (ctl.clear),
        .base_col  (wr_addr[COL_W-1:0]),
        .take      (ctl.take),
        .byte_in   (byte_data),
        .col_o     (cap_col),
        .count_o   (cap_cnt),
        .page_data (cap_data),
        .valid_mask(cap_mask)
    );

    pgw_scan #(
        .PAGE_BYTES(PAGE_BYTES),
        .COL_W     (COL_W)
    ) u_scan (
        .clk     (clk),
        .rst     (rst),
        .start   (ctl.commit),
        .base_col(base_q[COL_W-1:0]),
        .active  (scan_active),
        .col     (scan_col),
        .last    (scan_last)
    );

    pgw_timer #(
        .CYCLES(WRITE_CYCLES),
        .TIM_W (TIM_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (scan_last),
        .running(tim_running),
        .expire (tim_expire)
    );

    assign arr_we    = scan_active && cap_mask[scan_col];
    assign arr_addr  = {base_page, scan_col};
    assign arr_wdata = cap_data[scan_col*DATA_W +: DATA_W];
    assign busy      = (state_q == PGW_COMMIT) || (state_q == PGW_WAIT) || tim_running;
    assign ptr       = ptr_q;

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W       = 13,
    parameter int COL_W        = 5,
    parameter int CNT_W        = 6,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [ADDR_W-1:0] ptr,
    input logic              stop_stb,
    input logic              low_vdd,
    input logic              wr_start,
    input logic              recv_st,
    input logic [CNT_W-1:0]  cap_cnt
);

    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst)
            busy_run <= 0;
        else if (busy)
            busy_run <= busy_run + 1;
        else
            busy_run <= 0;
    end

    assert_we_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |->
            (arr_addr[ADDR_W-1:COL_W] == $past(arr_addr[ADDR_W-1:COL_W])));

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == PAGE_BYTES + WRITE_CYCLES));

    assert_low_supply_R7: assert property (@(posedge clk) disable iff (rst)
        (recv_st && stop_stb && !wr_start && low_vdd) |=> !busy);

    assert_empty_stop_R11: assert property (@(posedge clk) disable iff (rst)
        (recv_st && stop_stb && !wr_start && cap_cnt == '0) |=> !busy);

    assert_ptr_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ptr));

endmodule

bind eeprom_page_writer pgw_checker #(
    .ADDR_W      (ADDR_W),
    .COL_W       (COL_W),
    .CNT_W       (CNT_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .arr_we  (arr_we),
    .arr_addr(arr_addr),
    .ptr     (ptr),
    .stop_stb(stop_stb),
    .low_vdd (low_vdd),
    .wr_start(wr_start),
    .recv_st (recv_st),
    .cap_cnt (cap_cnt)
);

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;

    localparam int AW   = 13;
    localparam int DW   = 8;
    localparam int PG   = 32;
    localparam int WCYC = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_start = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          byte_stb = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          stop_stb = 1'b0;
    logic          wp_pin = 1'b0;
    logic          low_vdd = 1'b0;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic          busy;
    logic [AW-1:0] ptr;

    int n_checks = 0;
    int n_err    = 0;
    logic [AW+DW-1:0] got_q[$];

    always #10 clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PG), .WRITE_CYCLES(WCYC)
    ) u0 (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .stop_stb(stop_stb),
        .wp_pin(wp_pin), .low_vdd(low_vdd), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy), .ptr(ptr)
    );

    always @(negedge clk)
        if (!rst && arr_we) got_q.push_back({arr_addr, arr_wdata});

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [DW-1:0] seed, input int k);
        return DW'(seed ^ DW'(k * 37));
    endfunction

    // drive one transaction; optional intrusion while busy
    task automatic drive_txn(input logic [AW-1:0] base, input int n,
                             input logic [DW-1:0] seed, input int wp_at,
                             input bit lv, input bit intrude,
                             output int pre_writes, output int busy_cyc);
        got_q.delete();
        @(negedge clk);
        wr_start = 1'b1; wr_addr = base;
        if (wp_at == 0) wp_pin = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_stb = 1'b1; byte_data = pat(seed, k);
            if (wp_at == k + 1) wp_pin = 1'b1;
            @(negedge clk);
            byte_stb = 1'b0;
            if (wp_at == k + 1) wp_pin = 1'b0;
        end
        stop_stb = 1'b1; low_vdd = lv;
        pre_writes = got_q.size();
        @(negedge clk);
        stop_stb = 1'b0; low_vdd = 1'b0; wp_pin = 1'b0;
        busy_cyc = 0;
        while (busy) begin
            busy_cyc++;
            if (intrude) begin
                if (busy_cyc == 2) begin wr_start = 1'b1; wr_addr = 13'h1F00; end
                if (busy_cyc == 3) begin wr_start = 1'b0; byte_stb = 1'b1; byte_data = 8'h5A; end
                if (busy_cyc == 5) begin byte_stb = 1'b0; stop_stb = 1'b1; end
                if (busy_cyc == 6) stop_stb = 1'b0;
            end
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // compare observed writes with the page model
    task automatic check_writes(input string req, input logic [AW-1:0] base,
                                input int n, input logic [DW-1:0] seed);
        logic [DW-1:0] mdata [PG];
        bit            mval  [PG];
        logic [AW+DW-1:0] exp_q[$];
        int bc = int'(base[4:0]);
        for (int c = 0; c < PG; c++) begin mval[c] = 0; mdata[c] = '0; end
        for (int k = 0; k < n; k++) begin
            mdata[(bc + k) % PG] = pat(seed, k);
            mval[(bc + k) % PG]  = 1;
        end
        for (int i = 0; i < PG; i++) begin
            int c = (bc + i) % PG;
            if (mval[c]) exp_q.push_back({base[AW-1:5], 5'(c), mdata[c]});
        end
        chk(got_q.size() == exp_q.size(), req, "write count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, "write addr/data", got_q[i], exp_q[i]);
    endtask

    function automatic logic [AW-1:0] exp_ptr(input logic [AW-1:0] base, input int n);
        if (n == 0 || n >= PG) return base;
        return {base[AW-1:5], 5'((int'(base[4:0]) + n) % PG)};
    endfunction

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(arr_we == 1'b0, "R1", "we after reset", arr_we, 0);
        chk(ptr == '0, "R1", "ptr after reset", ptr, 0);
    endtask

    task automatic t_normal(input string req, input logic [AW-1:0] base,
                            input int n, input logic [DW-1:0] seed);
        int pre, bcyc;
        drive_txn(base, n, seed, -1, 1'b0, 1'b0, pre, bcyc);
        chk(pre == 0, "R4", "writes before stop", pre, 0);
        chk(bcyc == PG + WCYC, "R5", "busy cycles", bcyc, PG + WCYC);
        check_writes(req, base, n, seed);
        chk(ptr == exp_ptr(base, n), req, "pointer", ptr, exp_ptr(base, n));
    endtask

    task automatic t_blocked(input string req, input logic [AW-1:0] base,
                             input int n, input int wp_at, input bit lv);
        int pre, bcyc;
        drive_txn(base, n, 8'h33, wp_at, lv, 1'b0, pre, bcyc);
        chk(bcyc == 0, req, "busy cycles", bcyc, 0);
        chk(got_q.size() == 0, req, "array writes", got_q.size(), 0);
        chk(ptr == exp_ptr(base, n), "R8", "pointer after blocked write", ptr, exp_ptr(base, n));
    endtask

    task automatic t_empty();
        int pre, bcyc;
        drive_txn(13'h0ABC, 0, 8'h00, -1, 1'b0, 1'b0, pre, bcyc);
        chk(bcyc == 0, "R11", "busy cycles", bcyc, 0);
        chk(got_q.size() == 0, "R11", "array writes", got_q.size(), 0);
        chk(ptr == 13'h0ABC, "R11", "pointer", ptr, 13'h0ABC);
    endtask

    task automatic t_intrude();
        int pre, bcyc;
        drive_txn(13'h00A3, 3, 8'hC1, -1, 1'b0, 1'b1, pre, bcyc);
        chk(bcyc == PG + WCYC, "R12", "busy cycles with intrusion", bcyc, PG + WCYC);
        check_writes("R12", 13'h00A3, 3, 8'hC1);
        chk(ptr == exp_ptr(13'h00A3, 3), "R12", "pointer", ptr, exp_ptr(13'h00A3, 3));
        chk(busy == 1'b0, "R12", "busy after intrusion", busy, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal("R2", 13'h0124, 1, 8'h11);     // single byte mid page, R8 pointer
        t_normal("R2", 13'h105C, 8, 8'h42);     // col 28, wraps through 31 to 0
        t_normal("R8", 13'h0300, 17, 8'h9E);    // R8 pointer mid page
        t_normal("R3", 13'h0765, 40, 8'h07);    // overrun, later bytes win, R9
        t_normal("R9", 13'h0A2A, 32, 8'hE4);    // exactly one page
        t_normal("R10", 13'h1FFF, 1, 8'hAB);    // column 31 single byte
        chk(ptr == 13'h1FE0, "R10", "pointer page start", ptr, 13'h1FE0);
        t_blocked("R6", 13'h0040, 4, 2, 1'b0);  // wp pulses mid transaction
        t_blocked("R6", 13'h0060, 2, 0, 1'b0);  // wp from start
        t_blocked("R7", 13'h0080, 5, -1, 1'b1); // low supply at stop
        t_empty();
        t_intrude();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule